// File: doc/BRIEF.md
# Multithreaded Warp Issue Scheduler

This block keeps a table of independent SIMD threads (warps). Each thread has its own program counter and a ready flag. When the issue slot is free, the block chooses one eligible thread by round-robin and sends that thread's instruction to a group of physical lanes. A thread is 32 lanes wide and the datapath has 16 lanes, so each instruction leaves in two beats: beat 0 covers lanes 0–15 and beat 1 covers lanes 16–31. The slot stays with that thread until both beats have been accepted. Latency is hidden by moving on to another ready thread at every new pick, not by waiting on a stalled one.

A retire port writes a thread's next PC and sets or clears its ready flag. A per-thread stall mask takes threads out of selection for as long as their stall bit is high. Issuing an instruction consumes the thread's ready flag, so a thread has one instruction in flight until the retire port arms it again.

The issue output is a valid/ready stream. The consumer applies back-pressure by holding `issue_ready` low. While `issue_valid` is high and `issue_ready` is low, the thread ID, PC and beat index are held unchanged and no new selection takes place. A transfer completes on a rising edge where both `issue_valid` and `issue_ready` are high. While `issue_valid` is low the slot is empty and accepts a new pick regardless of `issue_ready`.

Top module: `wis_issue_sched`

## Requirements
- R1: After reset `issue_valid` is 0, `issue_beat` is 0 and every thread is not ready.
- R2: A retire write (`retire_valid`=1) stores `retire_pc` as the thread's PC and `retire_ready` as its ready flag. A thread armed at edge k can be selected at edge k+1, and it is issued with the PC most recently written. A write with `retire_ready`=0 never leads to an issue.
- R3: Each issued instruction produces two transfers with the same thread ID and PC, first `issue_beat`=0 (lanes 0–15) and then `issue_beat`=1 (lanes 16–31). No other thread is issued between them.
- R4: A new thread is chosen from the eligible threads in round-robin order, starting at the ID one above the most recently issued thread and wrapping from 63 to 0. After reset the search starts at thread 0.
- R5: When the slot is free and no thread is eligible, `issue_valid` is 0 for that cycle.
- R6: A retire write to a thread in the same cycle as a selection takes precedence: that thread is excluded from the selection, and the written values apply afterwards.
- R7: While `issue_valid`=1 and `issue_ready`=0, the outputs stay stable and no selection occurs. Retire writes are still applied during this time.
- R8: Selecting a thread clears its ready flag. The thread is not issued again until a retire write sets the flag again.
- R9: A thread whose `stall_mask` bit is 1 is not selected. Its ready flag and PC are kept, and it becomes eligible again once the bit drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_valid | input | 1 | Retire write strobe |
| retire_tid | input | 6 | Thread written by the retire port |
| retire_pc | input | 32 | Next PC for that thread |
| retire_ready | input | 1 | New ready flag for that thread |
| stall_mask | input | 64 | Per-thread stall, 1 = not eligible |
| issue_ready | input | 1 | Consumer accepts the current beat |
| issue_valid | output | 1 | A beat is being offered |
| issue_tid | output | 6 | Thread ID of the beat |
| issue_pc | output | 32 | PC of the issued instruction |
| issue_beat | output | 1 | 0 = lanes 0–15, 1 = lanes 16–31 |

## Verification
All outputs come from registers. A selection made from the state and inputs present before edge k is visible on the outputs just after edge k. A retire write at edge k therefore reaches the outputs at edge k+1 at the earliest. A beat 1 follows its beat 0 at the first edge where beat 0 is accepted. The bench drives inputs at the falling edge and steps a cycle-accurate reference model at the same point. It then compares valid, thread ID, PC and beat one time unit after each rising edge, so each result is checked in the cycle it is due.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int unsigned DEF_THREADS = 64;
  localparam int unsigned DEF_PC_W    = 32;
  localparam int unsigned DEF_BEATS   = 2;
endpackage

// File: rtl/wis_thread_table.sv
module wis_thread_table #(
  parameter int unsigned NUM_THREADS = 64,
  parameter int unsigned PC_W        = 32,
  localparam int unsigned TID_W      = $clog2(NUM_THREADS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [TID_W-1:0]       wr_tid,
  input  logic [PC_W-1:0]        wr_pc,
  input  logic                   wr_rdy,
  input  logic                   clr_en,
  input  logic [TID_W-1:0]       clr_tid,
  input  logic [TID_W-1:0]       rd_tid,
  output logic [PC_W-1:0]        rd_pc,
  output logic [NUM_THREADS-1:0] rdy_vec
);
  logic [PC_W-1:0] pc_mem [NUM_THREADS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_vec <= '0;
      for (int i = 0; i < NUM_THREADS; i++) pc_mem[i] <= '0;
    end else begin
      // selection consumes the flag; a retire write (never to the same thread) lands after
      if (clr_en) rdy_vec[clr_tid] <= 1'b0;
      if (wr_en) begin
        rdy_vec[wr_tid] <= wr_rdy;
        pc_mem[wr_tid]  <= wr_pc;
      end
    end
  end

  assign rd_pc = pc_mem[rd_tid];
endmodule

// File: rtl/wis_rr_arbiter.sv
module wis_rr_arbiter #(
  parameter int unsigned NUM_THREADS = 64,
  localparam int unsigned TID_W      = $clog2(NUM_THREADS)
) (
  input  logic [NUM_THREADS-1:0] req,
  input  logic [TID_W-1:0]       last,
  output logic                   gnt_valid,
  output logic [TID_W-1:0]       gnt_tid
);
  always_comb begin
    logic [TID_W-1:0] idx;
    gnt_valid = 1'b0;
    gnt_tid   = '0;
    idx       = '0;
    // walk upward from the slot after the last winner, wrapping modulo the table size
    for (int i = 1; i <= NUM_THREADS; i++) begin
      idx = last + TID_W'(i);
      if (!gnt_valid && req[idx]) begin
        gnt_valid = 1'b1;
        gnt_tid   = idx;
      end
    end
  end
endmodule

// File: rtl/wis_issue_sched.sv
module wis_issue_sched #(
  parameter int unsigned NUM_THREADS = wis_pkg::DEF_THREADS,
  parameter int unsigned PC_W        = wis_pkg::DEF_PC_W,
  parameter int unsigned BEATS       = wis_pkg::DEF_BEATS,
  localparam int unsigned TID_W      = $clog2(NUM_THREADS),
  localparam int unsigned BEAT_W     = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   retire_valid,
  input  logic [TID_W-1:0]       retire_tid,
  input  logic [PC_W-1:0]        retire_pc,
  input  logic                   retire_ready,
  input  logic [NUM_THREADS-1:0] stall_mask,
  input  logic                   issue_ready,
  output logic                   issue_valid,
  output logic [TID_W-1:0]       issue_tid,
  output logic [PC_W-1:0]        issue_pc,
  output logic [BEAT_W-1:0]      issue_beat
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic [NUM_THREADS-1:0] rdy_vec, wr_mask, eligible;
  logic [TID_W-1:0]       last_tid, gnt_tid;
  logic                   gnt_valid, slot_free, more_beats, do_pick;
  logic [PC_W-1:0]        gnt_pc;

  assign slot_free  = !issue_valid || issue_ready;
  assign more_beats = issue_valid && (issue_beat != LAST_BEAT);
  assign do_pick    = slot_free && !more_beats;

  always_comb begin
    wr_mask = '0;
    if (retire_valid) wr_mask[retire_tid] = 1'b1;
  end
  assign eligible = rdy_vec & ~stall_mask & ~wr_mask;

  wis_rr_arbiter #(.NUM_THREADS(NUM_THREADS)) u_arb (
    .req       (eligible),
    .last      (last_tid),
    .gnt_valid (gnt_valid),
    .gnt_tid   (gnt_tid)
  );

  wis_thread_table #(.NUM_THREADS(NUM_THREADS), .PC_W(PC_W)) u_tab (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (retire_valid),
    .wr_tid  (retire_tid),
    .wr_pc   (retire_pc),
    .wr_rdy  (retire_ready),
    .clr_en  (do_pick && gnt_valid),
    .clr_tid (gnt_tid),
    .rd_tid  (gnt_tid),
    .rd_pc   (gnt_pc),
    .rdy_vec (rdy_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issue_valid <= 1'b0;
      issue_tid   <= '0;
      issue_pc    <= '0;
      issue_beat  <= '0;
      last_tid    <= TID_W'(NUM_THREADS - 1);
    end else if (slot_free) begin
      if (more_beats) begin
        issue_beat <= issue_beat + 1'b1;
      end else if (gnt_valid) begin
        issue_valid <= 1'b1;
        issue_tid   <= gnt_tid;
        issue_pc    <= gnt_pc;
        issue_beat  <= '0;
        last_tid    <= gnt_tid;
      end else begin
        issue_valid <= 1'b0;
        issue_beat  <= '0;
      end
    end
  end
endmodule

// File: rtl/wis_issue_sched_chk.sv
module wis_issue_sched_chk #(
  parameter int unsigned NUM_THREADS = 64,
  parameter int unsigned PC_W        = 32,
  parameter int unsigned BEATS       = 2,
  localparam int unsigned TID_W      = $clog2(NUM_THREADS),
  localparam int unsigned BEAT_W     = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   retire_valid,
  input logic [TID_W-1:0]       retire_tid,
  input logic [NUM_THREADS-1:0] stall_mask,
  input logic                   issue_ready,
  input logic                   issue_valid,
  input logic [TID_W-1:0]       issue_tid,
  input logic [PC_W-1:0]        issue_pc,
  input logic [BEAT_W-1:0]      issue_beat
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic                   pick_cyc;
  logic [NUM_THREADS-1:0] stall_q;

  assign pick_cyc = (!issue_valid || issue_ready) &&
                    !(issue_valid && issue_beat != LAST_BEAT);

  always_ff @(posedge clk) begin
    if (!rst_n) stall_q <= '0;
    else        stall_q <= stall_mask;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !issue_valid && issue_beat == '0);

  a_r3_next_beat: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && issue_ready && issue_beat != LAST_BEAT |=>
      issue_valid && issue_beat == $past(issue_beat) + 1'b1 &&
      issue_tid == $past(issue_tid) && issue_pc == $past(issue_pc));

  a_r3_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && issue_ready && issue_beat == LAST_BEAT |=>
      !issue_valid || issue_beat == '0);

  a_r6_retire_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pick_cyc && retire_valid |=>
      !(issue_valid && issue_beat == '0 && issue_tid == $past(retire_tid)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !issue_ready |=>
      issue_valid && $stable(issue_tid) && $stable(issue_pc) && $stable(issue_beat));

  a_r9_stalled_skip: assert property (@(posedge clk) disable iff (!rst_n)
    pick_cyc |=> !(issue_valid && stall_q[issue_tid]));
endmodule

bind wis_issue_sched wis_issue_sched_chk #(
  .NUM_THREADS(NUM_THREADS), .PC_W(PC_W), .BEATS(BEATS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .retire_valid (retire_valid),
  .retire_tid   (retire_tid),
  .stall_mask   (stall_mask),
  .issue_ready  (issue_ready),
  .issue_valid  (issue_valid),
  .issue_tid    (issue_tid),
  .issue_pc     (issue_pc),
  .issue_beat   (issue_beat)
);

// File: tb/sim_wis_issue_sched.sv
`timescale 1ns/1ps
module sim_wis_issue_sched;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire_valid = 1'b0;
  logic [5:0]  retire_tid = '0;
  logic [31:0] retire_pc = '0;
  logic        retire_ready = 1'b0;
  logic [63:0] stall_mask = '0;
  logic        issue_ready = 1'b1;
  logic        issue_valid;
  logic [5:0]  issue_tid;
  logic [31:0] issue_pc;
  logic        issue_beat;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  bit          m_rdy [N];
  logic [31:0] m_pcs [N];
  int          m_last;
  bit          m_valid;
  int          m_tid;
  logic [31:0] m_opc;
  bit          m_beat;

  always #10 clk = ~clk;

  wis_issue_sched u0 (
    .clk(clk), .rst_n(rst_n), .retire_valid(retire_valid), .retire_tid(retire_tid),
    .retire_pc(retire_pc), .retire_ready(retire_ready), .stall_mask(stall_mask),
    .issue_ready(issue_ready), .issue_valid(issue_valid), .issue_tid(issue_tid),
    .issue_pc(issue_pc), .issue_beat(issue_beat)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 100000", cycles);
      finish_run();
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void model_reset();
    for (int i = 0; i < N; i++) begin m_rdy[i] = 0; m_pcs[i] = '0; end
    m_last = N - 1; m_valid = 0; m_tid = 0; m_opc = '0; m_beat = 0;
  endfunction

  function automatic void model_step();
    bit adv, found;
    int t;
    adv = !m_valid || issue_ready;
    if (adv) begin
      if (m_valid && !m_beat) m_beat = 1;
      else begin
        found = 0;
        for (int i = 1; i <= N; i++) begin
          t = (m_last + i) % N;
          if (!found && m_rdy[t] && !stall_mask[t] && !(retire_valid && retire_tid == t)) begin
            found = 1; m_valid = 1; m_tid = t; m_opc = m_pcs[t]; m_beat = 0;
            m_rdy[t] = 0; m_last = t;
          end
        end
        if (!found) begin m_valid = 0; m_beat = 0; end
      end
    end
    if (retire_valid) begin
      m_rdy[retire_tid] = retire_ready;
      m_pcs[retire_tid] = retire_pc;
    end
  endfunction

  // inputs are set at the falling edge before this is called
  task automatic step(string tag);
    model_step();
    @(posedge clk);
    #1;
    chk(tag, "valid", issue_valid, m_valid);
    if (m_valid) begin
      chk(tag, "tid", issue_tid, m_tid);
      chk(tag, "pc", issue_pc, m_opc);
      chk(tag, "beat", issue_beat, m_beat);
    end
    @(negedge clk);
  endtask

  task automatic retire(int tid, logic [31:0] pc, bit rdy);
    retire_valid = 1; retire_tid = 6'(tid); retire_pc = pc; retire_ready = rdy;
  endtask

  task automatic idle();
    retire_valid = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "valid", issue_valid, 0);
    chk("R1", "beat", issue_beat, 0);
    @(negedge clk);
    rst_n = 1;
    // R5: nothing ready -> bubbles
    repeat (3) step("R5");
    // R2 / R3 / R8: single thread
    retire(10, 32'h0000_0100, 1); step("R2");
    idle(); step("R2");      // beat 0 of thread 10
    step("R3");              // beat 1
    step("R8");              // flag consumed -> bubble
    step("R8");
    // R2: write with ready cleared never issues
    retire(41, 32'h0000_4100, 0); step("R2");
    idle(); step("R2"); step("R2");
    // R9 + R4: arm three threads while stalled, then release
    stall_mask = '1;
    retire(3, 32'h300, 1);  step("R9");
    retire(60, 32'h600, 1); step("R9");
    retire(20, 32'h200, 1); step("R9");
    idle(); step("R9"); step("R9");
    stall_mask = '0;
    repeat (6) step("R4");   // order 20, 60, 3 after last=10
    step("R5");
    // R6: retire to the only ready thread in its pick cycle
    retire(33, 32'hAAAA_0000, 1); step("R6");
    retire(33, 32'hBBBB_0000, 1); step("R6");  // excluded -> bubble
    idle(); step("R6");      // thread 33 with new PC
    step("R6");
    // R7: back-pressure hold
    retire(40, 32'hC0C0_0000, 1); step("R7");
    idle(); issue_ready = 0;
    step("R7");              // empty slot still loads
    retire(44, 32'h4444, 1); step("R7");
    idle(); step("R7"); step("R7");
    issue_ready = 1;
    step("R7"); step("R7"); step("R7");
    // random traffic
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 99) < 60)
        retire(int'($urandom_range(0, N - 1)), $urandom(), ($urandom_range(0, 9) != 0));
      else idle();
      issue_ready = ($urandom_range(0, 3) != 0);
      stall_mask  = {$urandom(), $urandom()} & {$urandom(), $urandom()} & {$urandom(), $urandom()};
      step("R4");
    end
    finish_run();
  end
endmodule